// File: doc/BRIEF.md
# Bisync Hunt-Mode Sync Detector

This block is the character framer on the receive side of a synchronous serial receiver. Serial data arrives one bit per cycle of `bit_valid`, already recovered from the line clock. While hunting, the block keeps a sliding window over the most recent bits and compares it with one or two programmed sync characters on every received bit. When the full sync pattern has been seen, it raises `syn_det`, stops hunting and groups the bits that follow into characters of the programmed length. Each character carries an optional parity bit.

Completed characters are placed in a single holding register and flagged with `rx_ready`. A character that completes while the previous one is still unread sets an overrun flag, and a parity mismatch sets a parity flag. Both flags stay set until an error-clear pulse. A read pulse on the status path clears `syn_det`. A hunt pulse discards any partial character and starts the search again.

The controller has three states. `ST_HUNT1` slides over the stream looking for the first sync character. `ST_HUNT2` (dual-sync mode only) counts one character time and then compares against the second sync character. `ST_FRAME` assembles data. The transitions are:
- HUNT1→HUNT2 when the first character matches in dual-sync mode.
- HUNT1→FRAME when it matches in single-sync mode.
- HUNT2→FRAME when the second character matches.
- HUNT2→HUNT2 (restart) when the second-character window matches the first sync character instead.
- HUNT2→HUNT1 on any other mismatch.
- any state→HUNT1 on `hunt_cmd`.

Top module: `bsync_rx_framer`

## Requirements
- R1: After reset, `hunting`=1 and `syn_det`, `rx_ready`, `par_err` and `ovr_err` are all 0.
- R2: The character length N is 5, 6, 7 or 8 for `char_len` 00, 01, 10 or 11. Bits arrive least significant first. While hunting, the window formed by the last N bits received since hunt entry is compared with the low N bits of `sync_a` on every bit, not only on character boundaries.
- R3: In single-sync mode (`dual_sync`=0), a match on `sync_a` ends hunting (`hunting`=0) and sets `syn_det`.
- R4: In dual-sync mode, `syn_det` is set and hunting ends only when the N bits immediately following a `sync_a` match equal the low N bits of `sync_b`. On a mismatch, the block keeps hunting: it restarts the second-character count if those N bits equal `sync_a`, and otherwise resumes sliding.
- R5: The first data character starts with the bit right after the last sync bit. Its N data bits appear LSB-first, zero-extended, on `rx_data`, and `rx_ready` rises within two clock edges of the edge that samples the completing bit.
- R6: With `par_en`=1, one parity bit follows the N data bits. For `par_even`=1 the count of ones over data plus parity must be even, and for `par_even`=0 it must be odd. A mismatch sets `par_err`.
- R7: A character that completes while `rx_ready` is still 1 sets `ovr_err` and replaces `rx_data`.
- R8: `data_rd` clears `rx_ready`, `err_clr` clears `par_err` and `ovr_err`, and `status_rd` clears `syn_det`. A set in the same cycle wins over a clear.
- R9: `hunt_cmd` returns the block to hunting from any state on the next edge and discards any partial character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | One received bit is present on `bit_in` |
| bit_in | input | 1 | Received serial bit |
| char_len | input | 2 | Character length code (00=5 … 11=8) |
| dual_sync | input | 1 | 1 = two sync characters required |
| par_en | input | 1 | Parity bit present after data |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| sync_a | input | 8 | First sync character (low N bits used) |
| sync_b | input | 8 | Second sync character (low N bits used) |
| hunt_cmd | input | 1 | Pulse: re-enter hunt mode |
| status_rd | input | 1 | Pulse: status read, clears `syn_det` |
| data_rd | input | 1 | Pulse: holding register read |
| err_clr | input | 1 | Pulse: clear error flags |
| hunting | output | 1 | Block is searching for sync |
| syn_det | output | 1 | Sync pattern found |
| rx_ready | output | 1 | Holding register has an unread character |
| rx_data | output | 8 | Received character, zero-extended |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun error flag |

## Verification
The hardest case to reach is the dual-sync path in which a valid first sync character is followed by a wrong second one. In that case the controller must drop back to sliding without losing the window history. The stimulus sends the first sync character, then N zero bits that match neither sync character, and then the full pair, and checks that sync is declared only on the pair. The preamble lengths are deliberately not multiples of N, so a detector that compared only on character boundaries would miss the pattern. The sweep covers every length, both sync modes and all three parity settings.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT1 = 2'd0,
        ST_HUNT2 = 2'd1,
        ST_FRAME = 2'd2
    } bsr_state_e;
endpackage

// File: rtl/bsr_window.sv
module bsr_window #(
    parameter int DW = 8,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic [LW-1:0] n_bits,
    output logic [DW-1:0] cand,
    output logic          full_nxt
);
    logic [DW-1:0] win_q;
    logic [DW-1:0] win_nxt;
    logic [LW-1:0] fill_q;
    logic [LW-1:0] fill_nxt;

    always_comb begin
        win_nxt  = {bit_in, win_q[DW-1:1]};
        cand     = win_nxt >> (LW'(DW) - n_bits);
        fill_nxt = (fill_q == LW'(DW)) ? fill_q : fill_q + LW'(1);
        full_nxt = (fill_nxt >= n_bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (clr) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (bit_valid) begin
            win_q  <= win_nxt;
            fill_q <= fill_nxt;
        end
    end

    // R2: window fill never exceeds the window width
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= LW'(DW));
endmodule

// File: rtl/bsr_assembler.sv
module bsr_assembler #(
    parameter int DW = 8,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          bit_in,
    input  logic [LW-1:0] n_bits,
    input  logic          par_en,
    input  logic          par_even,
    output logic          char_done,
    output logic [DW-1:0] char_data,
    output logic          char_perr
);
    logic [LW-1:0] cnt_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] acc_nxt;
    logic          last_bit;
    logic          odd_sum;

    always_comb begin
        acc_nxt = acc_q;
        if (cnt_q < n_bits) begin
            acc_nxt = acc_q | (DW'(bit_in) << cnt_q);
        end
        last_bit = par_en ? (cnt_q == n_bits) : (cnt_q == n_bits - LW'(1));
        odd_sum  = (^acc_q) ^ bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            char_done <= 1'b0;
            char_data <= '0;
            char_perr <= 1'b0;
        end else begin
            char_done <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else if (en) begin
                if (last_bit) begin
                    char_done <= 1'b1;
                    char_data <= acc_nxt;
                    char_perr <= par_en && (par_even ? odd_sum : !odd_sum);
                    cnt_q     <= '0;
                    acc_q     <= '0;
                end else begin
                    cnt_q <= cnt_q + LW'(1);
                    acc_q <= acc_nxt;
                end
            end
        end
    end

    // R6: no parity error is reported when parity is disabled
    a_r6_no_perr_without_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !par_en) |=> !(char_done && char_perr));
endmodule

// File: rtl/bsr_hold.sv
module bsr_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_done,
    input  logic [DW-1:0] char_data,
    input  logic          char_perr,
    input  logic          data_rd,
    input  logic          err_clr,
    output logic          rx_ready,
    output logic [DW-1:0] rx_data,
    output logic          par_err,
    output logic          ovr_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
            rx_data  <= '0;
            par_err  <= 1'b0;
            ovr_err  <= 1'b0;
        end else begin
            if (err_clr) begin
                par_err <= 1'b0;
                ovr_err <= 1'b0;
            end
            if (data_rd) begin
                rx_ready <= 1'b0;
            end
            if (char_done) begin
                rx_data  <= char_data;
                rx_ready <= 1'b1;
                if (rx_ready) begin
                    ovr_err <= 1'b1;
                end
                if (char_perr) begin
                    par_err <= 1'b1;
                end
            end
        end
    end

    // R7: completing into a full register raises overrun
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_ready) |=> ovr_err);
    // R8: a read without a new character empties the register
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !char_done) |=> !rx_ready);
    // R8: error clear without a new character drops both flags
    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !char_done) |=> (!par_err && !ovr_err));
    // R5: ready only rises after a completed character
    a_r5_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(char_done));
endmodule

// File: rtl/bsync_rx_framer.sv
module bsync_rx_framer #(
    parameter int DW = 8,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic [1:0]    char_len,
    input  logic          dual_sync,
    input  logic          par_en,
    input  logic          par_even,
    input  logic [7:0]    sync_a,
    input  logic [7:0]    sync_b,
    input  logic          hunt_cmd,
    input  logic          status_rd,
    input  logic          data_rd,
    input  logic          err_clr,
    output logic          hunting,
    output logic          syn_det,
    output logic          rx_ready,
    output logic [7:0]    rx_data,
    output logic          par_err,
    output logic          ovr_err
);
    import bsr_pkg::*;

    localparam int MIN_LEN = 5;

    bsr_state_e    state_q, state_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] n_bits;
    logic [DW-1:0] len_mask;
    logic [DW-1:0] cand;
    logic          full_nxt;
    logic          hit_a, hit_b;
    logic          sync_hit;
    logic          asm_en, asm_clr;
    logic          char_done, char_perr;
    logic [DW-1:0] char_data;

    always_comb begin
        n_bits   = LW'(MIN_LEN) + LW'(char_len);
        len_mask = {DW{1'b1}} >> (LW'(DW) - n_bits);
        hit_a    = full_nxt && (cand == (DW'(sync_a) & len_mask));
        hit_b    = (cand == (DW'(sync_b) & len_mask));
        asm_en   = bit_valid && (state_q == ST_FRAME) && !hunt_cmd;
        asm_clr  = hunt_cmd || (state_q != ST_FRAME);
    end

    bsr_window #(.DW(DW), .LW(LW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hunt_cmd),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .n_bits   (n_bits),
        .cand     (cand),
        .full_nxt (full_nxt)
    );

    bsr_assembler #(.DW(DW), .LW(LW)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (asm_clr),
        .en       (asm_en),
        .bit_in   (bit_in),
        .n_bits   (n_bits),
        .par_en   (par_en),
        .par_even (par_even),
        .char_done(char_done),
        .char_data(char_data),
        .char_perr(char_perr)
    );

    bsr_hold #(.DW(DW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_done(char_done),
        .char_data(char_data),
        .char_perr(char_perr),
        .data_rd  (data_rd),
        .err_clr  (err_clr),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .par_err  (par_err),
        .ovr_err  (ovr_err)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        sync_hit = 1'b0;
        if (hunt_cmd) begin
            state_d = ST_HUNT1;
            cnt_d   = '0;
        end else if (bit_valid) begin
            unique case (state_q)
                ST_HUNT1: begin
                    if (hit_a) begin
                        if (dual_sync) begin
                            state_d = ST_HUNT2;
                            cnt_d   = '0;
                        end else begin
                            state_d  = ST_FRAME;
                            sync_hit = 1'b1;
                        end
                    end
                end
                ST_HUNT2: begin
                    if (cnt_q == n_bits - LW'(1)) begin
                        cnt_d = '0;
                        if (hit_b) begin
                            state_d  = ST_FRAME;
                            sync_hit = 1'b1;
                        end else if (hit_a) begin
                            state_d = ST_HUNT2;
                        end else begin
                            state_d = ST_HUNT1;
                        end
                    end else begin
                        cnt_d = cnt_q + LW'(1);
                    end
                end
                ST_FRAME: begin
                    state_d = ST_FRAME;
                end
                default: begin
                    state_d = ST_HUNT1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT1;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_det <= 1'b0;
        end else begin
            if (status_rd) begin
                syn_det <= 1'b0;
            end
            if (sync_hit) begin
                syn_det <= 1'b1;
            end
        end
    end

    assign hunting = (state_q != ST_FRAME);

    // R3: sync detection coincides with leaving hunt
    a_r3_syndet_leaves_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_det) |-> !hunting);
    // R4: in dual mode the first state never jumps straight to framing
    a_r4_dual_two_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT1 && dual_sync) |=> (state_q != ST_FRAME));
    // R9: a hunt command always re-arms the search
    a_r9_hunt_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> hunting);
    // R8: status read without a new detection clears the flag
    a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !sync_hit) |=> !syn_det);
endmodule

// File: tb/bsync_rx_framer_bench.sv
module bsync_rx_framer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] char_len = 2'd0;
    logic       dual_sync = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic [7:0] sync_a = 8'h00;
    logic [7:0] sync_b = 8'h00;
    logic       hunt_cmd = 1'b0;
    logic       status_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic       err_clr = 1'b0;
    logic       hunting, syn_det, rx_ready, par_err, ovr_err;
    logic [7:0] rx_data;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bsync_rx_framer u_bsync_rx_framer (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .char_len(char_len), .dual_sync(dual_sync), .par_en(par_en),
        .par_even(par_even), .sync_a(sync_a), .sync_b(sync_b),
        .hunt_cmd(hunt_cmd), .status_rd(status_rd), .data_rd(data_rd),
        .err_clr(err_clr), .hunting(hunting), .syn_det(syn_det),
        .rx_ready(rx_ready), .rx_data(rx_data), .par_err(par_err),
        .ovr_err(ovr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (len=%0d dual=%0d par=%0d/%0d)",
                     req, act, exp, char_len + 5, dual_sync, par_en, par_even);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic pulse_ctl(input int which);
        @(negedge clk);
        case (which)
            0: hunt_cmd = 1'b1;
            1: status_rd = 1'b1;
            2: data_rd = 1'b1;
            default: err_clr = 1'b1;
        endcase
        @(negedge clk);
        hunt_cmd = 1'b0;
        status_rd = 1'b0;
        data_rd = 1'b0;
        err_clr = 1'b0;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(2);
        // R1: reset state
        check("R1 hunting", 32'(hunting), 32'd1);
        check("R1 flags", {28'd0, syn_det, rx_ready, par_err, ovr_err}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        check("R1 after release", {27'd0, hunting, syn_det, rx_ready, par_err, ovr_err}, 32'h10);

        for (int len = 0; len < 4; len++) begin
            for (int dual = 0; dual < 2; dual++) begin
                for (int pm = 0; pm < 3; pm++) begin
                    automatic int n = len + 5;
                    automatic logic [7:0] msk = 8'((1 << n) - 1);
                    automatic logic [7:0] d1 = 8'(len * 37 + pm * 11 + dual * 5 + 3) & msk;
                    automatic logic [7:0] d2 = ~d1 & msk;
                    automatic logic bad = (pm != 0) && (dual == 1);
                    automatic logic p1, p2;
                    char_len = 2'(len);
                    dual_sync = dual[0];
                    par_en = (pm != 0);
                    par_even = (pm == 1);
                    sync_a = 8'hFF;
                    sync_b = 8'h55;
                    p1 = par_even ? ^d1 : ~^d1;
                    p2 = (par_even ? ^d2 : ~^d2) ^ bad;

                    pulse_ctl(0);
                    pulse_ctl(1);
                    pulse_ctl(2);
                    pulse_ctl(3);
                    idle(1);
                    // R9: hunt command re-arms the search
                    check("R9 hunting after hunt_cmd", 32'(hunting), 32'd1);
                    // R2: preamble not aligned to N
                    send_char(8'h00, 3 + len);
                    if (dual == 1) begin
                        send_char(8'hFF, n);
                        idle(2);
                        check("R4 first sync alone", {30'd0, hunting, syn_det}, 32'h2);
                        send_char(8'h00, n);
                        idle(2);
                        check("R4 wrong second sync", {30'd0, hunting, syn_det}, 32'h2);
                        send_char(8'hFF, n);
                        send_char(8'h55, n);
                    end else begin
                        send_char(8'hFF, n);
                    end
                    idle(2);
                    check("R3 sync found", {30'd0, hunting, syn_det}, 32'h1);
                    pulse_ctl(1);
                    idle(1);
                    check("R8 status read clears syn_det", 32'(syn_det), 32'd0);

                    send_char(d1, n);
                    if (par_en) send_bit(p1);
                    idle(3);
                    check("R5 ready", 32'(rx_ready), 32'd1);
                    check("R5 data", 32'(rx_data), 32'(d1));
                    check("R6 clean parity", {30'd0, par_err, ovr_err}, 32'd0);

                    send_char(d2, n);
                    if (par_en) send_bit(p2);
                    idle(3);
                    check("R7 overrun data", 32'(rx_data), 32'(d2));
                    check("R7 overrun flag", 32'(ovr_err), 32'd1);
                    check("R6 parity error", 32'(par_err), 32'(bad));

                    pulse_ctl(2);
                    pulse_ctl(3);
                    idle(1);
                    check("R8 clears", {29'd0, rx_ready, par_err, ovr_err}, 32'd0);
                end
            end
        end

        // R9: hunt command in the middle of a character discards it
        pulse_ctl(0);
        pulse_ctl(1);
        char_len = 2'd3;
        dual_sync = 1'b0;
        par_en = 1'b0;
        send_char(8'hFF, 8);
        send_char(8'h0F, 4);
        pulse_ctl(0);
        idle(1);
        check("R9 partial dropped", {30'd0, hunting, rx_ready}, 32'h2);
        send_char(8'hFF, 8);
        send_char(8'hA5, 8);
        idle(3);
        check("R9 fresh char after rearm", 32'(rx_data), 32'hA5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule